// File: doc/BRIEF.md
# Sub-Sampling Sensor Readout Timing Generator

This block paces the readout of a colour-mosaic image sensor. Running on the pixel clock, it walks a programmable window of rows and columns and marks each pixel that is read out. It raises a line-valid level for the active part of each line and a frame-valid level across the active lines. With every pixel it gives the physical row and column of that pixel inside the window. Row and column sub-sampling drop whole 2x2 mosaic cells, so the colour phase of the pixel stream never changes. The programmed window, together with horizontal and vertical blanking, forms a virtual frame, and the lengths of the line and the frame set the line rate and the frame rate.

The configuration inputs are sampled once per frame, at the clock edge that ends the last active line. From that point the new settings govern the vertical blanking lines and the next frame. A registered error flag reports a setting that the analog chain cannot support: blanking that is too short, or a line too short for the selected converter resolution and clock division.

Top module: `sfr_readout_timing`

## Requirements
- R1: While reset is high, pixel-valid, line-valid, frame-valid, both addresses and the error flag are 0. After reset is released, the clock edge that follows is an idle cycle, and the next edge presents the pixel at row 0, column 0.
- R2: Column c is read out when c < window columns and (c div 2) mod (column skip + 1) = 0, where column skip is the 2-bit field 0..3. Within a line, the kept columns come one per clock in ascending order, with col_addr = c. Pixel-valid equals line-valid on every cycle.
- R3: Row r is read out when r < window rows and (r div 2) mod (row skip + 1) = 0. Kept rows come in ascending order, one line each, and row_addr = r for every pixel of that line.
- R4: Kept pixels form even/odd pairs. An even address is followed on the next clock of the same line by the next odd address, and an odd address by a larger even one.
- R5: Every line lasts (kept columns + hblank) clocks. During the hblank clocks line-valid is low, and both addresses read 0 whenever line-valid is low.
- R6: After the last kept row, vblank further lines follow, each with the same length as an active line. Frame-valid is high from the first pixel of a frame until the end of its last line's hblank, and low during vertical blanking. Line-valid high implies frame-valid high.
- R7: The error flag is 1 when the latched hblank is below 60 or the latched vblank is below 4.
- R8: The error flag is also 1 when floor(window columns / (column skip + 1)) + hblank ≤ ((adc_res + 1) × 256 >> clk_div) + 200.
- R9: The configuration is taken only at the edge that ends the last active line of a frame. A change made during a frame alters neither that frame's geometry nor the error flag. The error flag changes on the first vertical blanking cycle, and it holds steady through the active part of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_cols | input | COL_W | Window width in physical columns |
| cfg_win_rows | input | ROW_W | Window depth in physical rows |
| cfg_col_skip | input | 2 | Column sub-sampling factor |
| cfg_row_skip | input | 2 | Row sub-sampling factor |
| cfg_hblank | input | HB_W | Horizontal blanking in clocks |
| cfg_vblank | input | VB_W | Vertical blanking in lines |
| cfg_adc_res | input | ADC_W | Converter resolution setting |
| cfg_clk_div | input | DIV_W | Converter clock division exponent |
| pix_valid | output | 1 | A kept pixel is presented this cycle |
| line_valid | output | 1 | Active part of a line |
| frame_valid | output | 1 | Active lines of a frame |
| row_addr | output | ROW_W | Physical row of the current pixel |
| col_addr | output | COL_W | Physical column of the current pixel |
| cfg_err | output | 1 | Latched configuration is illegal |

## Verification
The bench builds the block with its default widths. Ten address bits on each axis cover windows of up to 192 columns. A 10-bit hblank field reaches from values just below the 60-clock minimum to lines of several hundred clocks, and a 6-bit vblank field reaches both sides of the 4-line minimum. Two bits each for converter resolution and division let the line-length threshold move from 232 to 1224 clocks, so the bench can land a line exactly on the threshold and one clock past it. With these widths the bench also exercises all four skip factors, including the factor-of-three case, on short frames.

// File: rtl/sfr_timing_pkg.sv
package sfr_timing_pkg;
  localparam int unsigned HBLANK_MIN = 60;
  localparam int unsigned VBLANK_MIN = 4;
  localparam int unsigned ADC_STEP   = 256;
  localparam int unsigned ADC_MARGIN = 200;

  typedef enum logic {
    PH_ACTIVE = 1'b0,
    PH_BLANK  = 1'b1
  } line_phase_e;
endpackage

// File: rtl/sfr_pair_stepper.sv
// Next kept coordinate along one axis: pairs are kept, then skip pairs dropped.
module sfr_pair_stepper #(
  parameter int POS_W = 10
) (
  input  logic [POS_W-1:0] pos,
  input  logic [1:0]       skip,
  input  logic [POS_W-1:0] limit,
  output logic [POS_W-1:0] nxt,
  output logic             last
);
  localparam int EXT_W = POS_W + 3;

  logic [EXT_W-1:0] cand;

  always_comb begin
    if (pos[0]) cand = EXT_W'(pos) + EXT_W'({skip, 1'b1});
    else        cand = EXT_W'(pos) + EXT_W'(1);
    last = (cand >= EXT_W'(limit));
    nxt  = cand[POS_W-1:0];
  end
endmodule

// File: rtl/sfr_cfg_latch.sv
// Frame-boundary shadow of the configuration and its legality check.
module sfr_cfg_latch
  import sfr_timing_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 10,
  parameter int HB_W  = 10,
  parameter int VB_W  = 6,
  parameter int ADC_W = 2,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch,
  input  logic [COL_W-1:0] in_cols,
  input  logic [ROW_W-1:0] in_rows,
  input  logic [1:0]       in_col_skip,
  input  logic [1:0]       in_row_skip,
  input  logic [HB_W-1:0]  in_hblank,
  input  logic [VB_W-1:0]  in_vblank,
  input  logic [ADC_W-1:0] in_adc,
  input  logic [DIV_W-1:0] in_div,
  output logic [COL_W-1:0] sh_cols,
  output logic [ROW_W-1:0] sh_rows,
  output logic [1:0]       sh_col_skip,
  output logic [1:0]       sh_row_skip,
  output logic [HB_W-1:0]  sh_hblank,
  output logic [VB_W-1:0]  sh_vblank,
  output logic             err
);
  localparam int WIDE_W = (COL_W > HB_W) ? COL_W : HB_W;
  localparam int CMP_W  = WIDE_W + ADC_W + 10;

  logic [ADC_W-1:0] sh_adc;
  logic [DIV_W-1:0] sh_div;
  logic [COL_W-1:0] eff_cols;
  logic [CMP_W-1:0] thr, line_len;
  logic             bad;

  always_ff @(posedge clk) begin
    if (rst || latch) begin
      sh_cols     <= in_cols;
      sh_rows     <= in_rows;
      sh_col_skip <= in_col_skip;
      sh_row_skip <= in_row_skip;
      sh_hblank   <= in_hblank;
      sh_vblank   <= in_vblank;
      sh_adc      <= in_adc;
      sh_div      <= in_div;
    end
  end

  always_comb begin
    case (sh_col_skip)
      2'd0:    eff_cols = sh_cols;
      2'd1:    eff_cols = sh_cols >> 1;
      2'd2:    eff_cols = sh_cols / COL_W'(3);
      default: eff_cols = sh_cols >> 2;
    endcase
    thr      = (((CMP_W'(sh_adc) + CMP_W'(1)) * CMP_W'(ADC_STEP)) >> sh_div)
               + CMP_W'(ADC_MARGIN);
    line_len = CMP_W'(eff_cols) + CMP_W'(sh_hblank);
    bad      = (CMP_W'(sh_hblank) < CMP_W'(HBLANK_MIN))
            || (CMP_W'(sh_vblank) < CMP_W'(VBLANK_MIN))
            || (line_len <= thr);
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad;
  end
endmodule

// File: rtl/sfr_line_timer.sv
// Horizontal walk: kept columns, then hblank clocks.
module sfr_line_timer
  import sfr_timing_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int HB_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [COL_W-1:0] cols,
  input  logic [1:0]       col_skip,
  input  logic [HB_W-1:0]  hblank,
  output logic             active,
  output logic [COL_W-1:0] col,
  output logic             line_end
);
  line_phase_e      phase;
  logic [HB_W-1:0]  hb_cnt;
  logic [COL_W-1:0] col_nxt;
  logic             col_last;

  sfr_pair_stepper #(.POS_W(COL_W)) u_col_step (
    .pos   (col),
    .skip  (col_skip),
    .limit (cols),
    .nxt   (col_nxt),
    .last  (col_last)
  );

  always_comb begin
    active = (phase == PH_ACTIVE);
    if (restart)     line_end = 1'b1;
    else if (active) line_end = col_last && (hblank == '0);
    else             line_end = ((HB_W+1)'(hb_cnt) + (HB_W+1)'(1)) >= (HB_W+1)'(hblank);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_BLANK;
      col    <= '0;
      hb_cnt <= '0;
    end else if (line_end) begin
      phase  <= PH_ACTIVE;
      col    <= '0;
      hb_cnt <= '0;
    end else if (active) begin
      if (col_last) begin
        phase  <= PH_BLANK;
        hb_cnt <= '0;
      end else begin
        col <= col_nxt;
      end
    end else begin
      hb_cnt <= hb_cnt + HB_W'(1);
    end
  end
endmodule

// File: rtl/sfr_frame_seq.sv
// Vertical walk: kept rows, then vblank lines; flags the frame boundary.
module sfr_frame_seq #(
  parameter int ROW_W = 10,
  parameter int VB_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             line_end,
  input  logic [ROW_W-1:0] rows,
  input  logic [1:0]       row_skip,
  input  logic [VB_W-1:0]  vblank_now,
  input  logic [VB_W-1:0]  vblank_new,
  output logic             in_vblank,
  output logic [ROW_W-1:0] row,
  output logic             frame_wrap
);
  logic [VB_W-1:0]  vb_cnt;
  logic [ROW_W-1:0] row_nxt;
  logic             row_last;

  sfr_pair_stepper #(.POS_W(ROW_W)) u_row_step (
    .pos   (row),
    .skip  (row_skip),
    .limit (rows),
    .nxt   (row_nxt),
    .last  (row_last)
  );

  assign frame_wrap = line_end && !restart && !in_vblank && row_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_vblank <= 1'b1;
      row       <= '0;
      vb_cnt    <= '0;
    end else if (restart) begin
      in_vblank <= 1'b0;
      row       <= '0;
    end else if (line_end) begin
      if (!in_vblank) begin
        if (row_last) begin
          row       <= '0;
          vb_cnt    <= '0;
          in_vblank <= (vblank_new != '0);
        end else begin
          row <= row_nxt;
        end
      end else if (((VB_W+1)'(vb_cnt) + (VB_W+1)'(1)) >= (VB_W+1)'(vblank_now)) begin
        in_vblank <= 1'b0;
        row       <= '0;
      end else begin
        vb_cnt <= vb_cnt + VB_W'(1);
      end
    end
  end
endmodule

// File: rtl/sfr_readout_timing.sv
module sfr_readout_timing #(
  parameter int COL_W = 10,
  parameter int ROW_W = 10,
  parameter int HB_W  = 10,
  parameter int VB_W  = 6,
  parameter int ADC_W = 2,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] cfg_win_cols,
  input  logic [ROW_W-1:0] cfg_win_rows,
  input  logic [1:0]       cfg_col_skip,
  input  logic [1:0]       cfg_row_skip,
  input  logic [HB_W-1:0]  cfg_hblank,
  input  logic [VB_W-1:0]  cfg_vblank,
  input  logic [ADC_W-1:0] cfg_adc_res,
  input  logic [DIV_W-1:0] cfg_clk_div,
  output logic             pix_valid,
  output logic             line_valid,
  output logic             frame_valid,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             cfg_err
);
  logic             boot;
  logic [COL_W-1:0] sh_cols;
  logic [ROW_W-1:0] sh_rows;
  logic [1:0]       sh_col_skip, sh_row_skip;
  logic [HB_W-1:0]  sh_hblank;
  logic [VB_W-1:0]  sh_vblank;
  logic             h_active, line_end, in_vblank, frame_wrap;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             lv_d;

  sfr_cfg_latch #(
    .COL_W(COL_W), .ROW_W(ROW_W), .HB_W(HB_W),
    .VB_W(VB_W), .ADC_W(ADC_W), .DIV_W(DIV_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .latch       (frame_wrap),
    .in_cols     (cfg_win_cols),
    .in_rows     (cfg_win_rows),
    .in_col_skip (cfg_col_skip),
    .in_row_skip (cfg_row_skip),
    .in_hblank   (cfg_hblank),
    .in_vblank   (cfg_vblank),
    .in_adc      (cfg_adc_res),
    .in_div      (cfg_clk_div),
    .sh_cols     (sh_cols),
    .sh_rows     (sh_rows),
    .sh_col_skip (sh_col_skip),
    .sh_row_skip (sh_row_skip),
    .sh_hblank   (sh_hblank),
    .sh_vblank   (sh_vblank),
    .err         (cfg_err)
  );

  sfr_line_timer #(.COL_W(COL_W), .HB_W(HB_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .restart  (boot),
    .cols     (sh_cols),
    .col_skip (sh_col_skip),
    .hblank   (sh_hblank),
    .active   (h_active),
    .col      (col),
    .line_end (line_end)
  );

  sfr_frame_seq #(.ROW_W(ROW_W), .VB_W(VB_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .restart    (boot),
    .line_end   (line_end),
    .rows       (sh_rows),
    .row_skip   (sh_row_skip),
    .vblank_now (sh_vblank),
    .vblank_new (cfg_vblank),
    .in_vblank  (in_vblank),
    .row        (row),
    .frame_wrap (frame_wrap)
  );

  assign lv_d = h_active && !in_vblank;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot        <= 1'b1;
      pix_valid   <= 1'b0;
      line_valid  <= 1'b0;
      frame_valid <= 1'b0;
      row_addr    <= '0;
      col_addr    <= '0;
    end else begin
      boot        <= 1'b0;
      pix_valid   <= lv_d;
      line_valid  <= lv_d;
      frame_valid <= !in_vblank;
      row_addr    <= lv_d ? row : '0;
      col_addr    <= lv_d ? col : '0;
    end
  end
endmodule

// File: rtl/sfr_readout_timing_chk.sv
module sfr_readout_timing_chk #(
  parameter int COL_W = 10,
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             line_valid,
  input logic             frame_valid,
  input logic [ROW_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr,
  input logic             cfg_err
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (!line_valid && !frame_valid && !pix_valid && !cfg_err));

  a_r2_pix_tracks_line: assert property (@(posedge clk) disable iff (rst)
    pix_valid == line_valid);

  a_r2_line_starts_col0: assert property (@(posedge clk) disable iff (rst)
    $rose(line_valid) |-> (col_addr == '0));

  a_r4_even_then_odd: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(line_valid) && !$past(col_addr[0]) && $stable(row_addr))
    |-> (col_addr == $past(col_addr) + COL_W'(1)));

  a_r4_odd_then_even: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(line_valid) && $past(col_addr[0]) && $stable(row_addr))
    |-> (!col_addr[0] && (col_addr > $past(col_addr))));

  a_r5_addr_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> ((col_addr == '0) && (row_addr == '0)));

  a_r6_line_in_frame: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> frame_valid);

  a_r3_row_held_in_line: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(line_valid) && (col_addr != '0)) |-> $stable(row_addr));

  a_r9_err_steady_in_frame: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && $past(frame_valid)
     && !(line_valid && (row_addr == '0) && (col_addr == '0)))
    |-> $stable(cfg_err));
endmodule

bind sfr_readout_timing sfr_readout_timing_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_valid   (pix_valid),
  .line_valid  (line_valid),
  .frame_valid (frame_valid),
  .row_addr    (row_addr),
  .col_addr    (col_addr),
  .cfg_err     (cfg_err)
);

// File: tb/sfr_readout_timing_tb.sv
module sfr_readout_timing_tb;
  localparam int COL_W = 10;
  localparam int ROW_W = 10;
  localparam int HB_W  = 10;
  localparam int VB_W  = 6;
  localparam int ADC_W = 2;
  localparam int DIV_W = 2;
  localparam int NF    = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic [COL_W-1:0] cfg_win_cols;
  logic [ROW_W-1:0] cfg_win_rows;
  logic [1:0]       cfg_col_skip, cfg_row_skip;
  logic [HB_W-1:0]  cfg_hblank;
  logic [VB_W-1:0]  cfg_vblank;
  logic [ADC_W-1:0] cfg_adc_res;
  logic [DIV_W-1:0] cfg_clk_div;
  logic             pix_valid, line_valid, frame_valid, cfg_err;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;

  always #5 clk = ~clk;

  sfr_readout_timing #(
    .COL_W(COL_W), .ROW_W(ROW_W), .HB_W(HB_W),
    .VB_W(VB_W), .ADC_W(ADC_W), .DIV_W(DIV_W)
  ) u_dut (
    .clk(clk), .rst(rst),
    .cfg_win_cols(cfg_win_cols), .cfg_win_rows(cfg_win_rows),
    .cfg_col_skip(cfg_col_skip), .cfg_row_skip(cfg_row_skip),
    .cfg_hblank(cfg_hblank), .cfg_vblank(cfg_vblank),
    .cfg_adc_res(cfg_adc_res), .cfg_clk_div(cfg_clk_div),
    .pix_valid(pix_valid), .line_valid(line_valid), .frame_valid(frame_valid),
    .row_addr(row_addr), .col_addr(col_addr), .cfg_err(cfg_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cw[NF+1], cd[NF+1], csc[NF+1], csr[NF+1];
  int chb[NF+1], cvb[NF+1], cadc[NF+1], cdiv[NF+1];

  function automatic bit exp_err(int k);
    int eff, thr;
    eff = cw[k] / (csc[k] + 1);
    thr = (((cadc[k] + 1) * 256) >> cdiv[k]) + 200;
    return (chb[k] < 60) || (cvb[k] < 4) || ((eff + chb[k]) <= thr);
  endfunction

  function automatic int kept_count(int lim, int sk);
    int n = 0;
    for (int i = 0; i < lim; i++) if (((i >> 1) % (sk + 1)) == 0) n++;
    return n;
  endfunction

  task automatic set_cfg(int k, int w, int d, int sc, int sr, int hb, int vb, int adc, int dv);
    cw[k] = w; cd[k] = d; csc[k] = sc; csr[k] = sr;
    chb[k] = hb; cvb[k] = vb; cadc[k] = adc; cdiv[k] = dv;
  endtask

  task automatic drive_cfg(int k);
    cfg_win_cols = COL_W'(cw[k]);
    cfg_win_rows = ROW_W'(cd[k]);
    cfg_col_skip = 2'(csc[k]);
    cfg_row_skip = 2'(csr[k]);
    cfg_hblank   = HB_W'(chb[k]);
    cfg_vblank   = VB_W'(cvb[k]);
    cfg_adc_res  = ADC_W'(cadc[k]);
    cfg_clk_div  = DIV_W'(cdiv[k]);
  endtask

  task automatic step(bit lv, bit fv, int r, int c, bit er, string req, string ereq);
    @(negedge clk);
    checks++;
    if (line_valid !== lv || pix_valid !== lv || frame_valid !== fv ||
        row_addr !== ROW_W'(r) || col_addr !== COL_W'(c)) begin
      failures++;
      $display("FAIL %s: got lv=%0b pv=%0b fv=%0b row=%0d col=%0d, expected lv=%0b fv=%0b row=%0d col=%0d",
               req, line_valid, pix_valid, frame_valid, row_addr, col_addr, lv, fv, r, c);
    end
    checks++;
    if (cfg_err !== er) begin
      failures++;
      $display("FAIL %s: got err=%0b, expected err=%0b", ereq, cfg_err, er);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    bit first, e_cur, e_nxt;
    int vlen;
    void'($urandom(32'd4242));
    set_cfg(0,  48,  8, 0, 0, 200, 4, 0, 3);  // legal baseline
    set_cfg(1, 192,  8, 0, 3,  59, 4, 0, 3);  // R7 hblank one below minimum
    set_cfg(2,  48,  8, 2, 2, 240, 3, 0, 3);  // R7 vblank below minimum, skip 2
    set_cfg(3,  48,  8, 1, 0, 208, 4, 0, 3);  // R8 line equals threshold
    set_cfg(4,  48,  8, 1, 1, 209, 4, 0, 3);  // R8 one clock above threshold
    set_cfg(5,  24,  8, 0, 0, 100, 4, 3, 0);  // R8 high resolution, no division
    set_cfg(6,  96, 16, 3, 3, 240, 5, 3, 3);  // skip 3 both axes
    for (int k = 7; k <= NF; k++)
      set_cfg(k, 24 * (1 + int'($urandom % 4)), 8 * (1 + int'($urandom % 2)),
              int'($urandom % 4), int'($urandom % 4), 40 + int'($urandom % 260),
              2 + int'($urandom % 6), int'($urandom % 4), 3);

    rst = 1'b1;
    drive_cfg(0);
    repeat (3) step(0, 0, 0, 0, 0, "R1 reset", "R1 reset");
    rst = 1'b0;
    step(0, 0, 0, 0, exp_err(0), "R1 idle", "R7/R8 initial");

    for (int k = 0; k < NF; k++) begin
      first = 1'b1;
      e_cur = exp_err(k);
      for (int r = 0; r < cd[k]; r++) begin
        if (((r >> 1) % (csr[k] + 1)) != 0) continue;
        for (int c = 0; c < cw[k]; c++) begin
          if (((c >> 1) % (csc[k] + 1)) != 0) continue;
          step(1, 1, r, c, e_cur, "R2 R3 R4 pixel", "R9 err held in frame");
          if (first) begin
            drive_cfg(k + 1);  // R9: new settings arrive mid-frame
            first = 1'b0;
          end
        end
        for (int h = 0; h < chb[k]; h++)
          step(0, 1, 0, 0, e_cur, "R5 hblank", "R9 err held in frame");
      end
      e_nxt = exp_err(k + 1);
      vlen  = kept_count(cw[k + 1], csc[k + 1]) + chb[k + 1];
      for (int v = 0; v < cvb[k + 1]; v++)
        for (int h = 0; h < vlen; h++)
          step(0, 0, 0, 0, e_nxt, "R6 vblank", "R7 R8 R9 err after boundary");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule